// File: doc/BRIEF.md
# Self-Test Result Pulse Signaller

This block turns the outcome of a short power-on self-test into a waveform on one status pin that a slow external tester can read. After reset, it waits for a start trigger. It then emits one announcement pulse and reports two data checks in a fixed order. The first check sums a set of constants and the second writes memory and reads it back. A pass is shown as a short, fast burst whose pulse count identifies the check. A failure keeps the same pulse count but uses visibly longer and wider pulses.

Each check delivers its verdict as a strobe with a pass flag, and the strobe may arrive at any time after reset. The block remembers each verdict until that check's slot in the sequence is reached. While a burst is being drawn, including its trailing quiet time, a busy flag is raised.

After both reports, the block enters a final phase and samples a hold input on every clock. The status pin is driven high once that input has been seen high for a set number of consecutive clocks. Any low sample restarts the count. Every duration is counted in clock cycles, and all durations are parameters.

Top module: `selftest_signaller`

## Requirements
- R1: While reset is asserted and right after it is released, `status_o` and `busy_o` are 0.
- R2: Before `start_i` is seen, `status_o` stays 0 whatever the strobes and `hold_i` do. Verdicts strobed in that time are kept and reported later.
- R3: On start, `status_o` gives exactly one pulse of `PASS_HI` clocks high. Every burst is followed by at least `GAP_LO` low clocks before the next burst begins.
- R4: A passing first check is shown as 2 pulses, each `PASS_HI` clocks high and `PASS_LO` clocks low.
- R5: A passing second check is shown as 3 pulses with the same pass shape.
- R6: A failing check keeps its pulse count (2 or 3), but each pulse is `FAIL_HI` clocks high and `FAIL_LO` clocks low.
- R7: The first check is always reported before the second, whatever order the strobes arrive in. A strobe that arrives while a burst is in progress is held until that burst ends.
- R8: `busy_o` is 1 from the first high clock of a burst through the end of its trailing gap, and 0 while waiting.
- R9: Only the first strobe of each check counts. Later strobes for the same check do not change its report.
- R10: In the final phase, `status_o` rises after `HOLD_CYCLES` consecutive clocks with `hold_i` sampled high. A low sample clears the run count.
- R11: Once `status_o` has risen in the final phase, it stays at 1 until reset, even if `hold_i` falls.
- R12: `hold_i` has no effect on `status_o` before the final phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts the reporting sequence; acted on while idle |
| sum_strobe_i | input | 1 | One-clock verdict strobe of the summed-constant check |
| sum_pass_i | input | 1 | Pass flag qualified by `sum_strobe_i` |
| mem_strobe_i | input | 1 | One-clock verdict strobe of the memory read-back check |
| mem_pass_i | input | 1 | Pass flag qualified by `mem_strobe_i` |
| hold_i | input | 1 | Level watched in the final phase |
| status_o | output | 1 | Single status pin seen by the tester |
| busy_o | output | 1 | High while a burst and its trailing gap are in progress |

## Verification
The bench builds the block with pulse timings of 2/2 (pass), 4/6 (fail), a gap of 8 and a hold threshold of 20. With these values a full sequence runs in a few dozen clocks instead of twenty thousand. It measures pulse counts, high and low lengths and the gaps between bursts from the pin itself. A fail low time of 6 against a gap of 8 lets the bench tell pulses within a burst from burst boundaries. A threshold of 20, longer than the 10-clock pre-glitch run, shows that a single low sample really restarts the count.

// File: rtl/stp_pkg.sv
package stp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_INTRO, PH_WAIT_A, PH_SHOW_A, PH_WAIT_B, PH_SHOW_B, PH_HOLD
  } phase_e;

  typedef enum logic [1:0] {PG_IDLE, PG_HIGH, PG_LOW, PG_GAP} pg_state_e;

  localparam int unsigned NUM_CHECKS = 2;
  localparam int unsigned PCOUNT_W   = 2;
endpackage

// File: rtl/stp_pulse_gen.sv
module stp_pulse_gen
  import stp_pkg::*;
#(
  parameter int unsigned PASS_HI = 4,
  parameter int unsigned PASS_LO = 4,
  parameter int unsigned FAIL_HI = 16,
  parameter int unsigned FAIL_LO = 48,
  parameter int unsigned GAP_LO  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_i,
  input  logic [PCOUNT_W-1:0] count_i,
  input  logic                slow_i,
  output logic                pulse_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int unsigned M1 = (PASS_HI > PASS_LO) ? PASS_HI : PASS_LO;
  localparam int unsigned M2 = (FAIL_HI > FAIL_LO) ? FAIL_HI : FAIL_LO;
  localparam int unsigned M3 = (M1 > M2) ? M1 : M2;
  localparam int unsigned MAXLEN = (M3 > GAP_LO) ? M3 : GAP_LO;
  localparam int unsigned TMR_W = $clog2(MAXLEN + 1);
  localparam logic [TMR_W-1:0] PH_M1 = TMR_W'(PASS_HI - 1);
  localparam logic [TMR_W-1:0] PL_M1 = TMR_W'(PASS_LO - 1);
  localparam logic [TMR_W-1:0] FH_M1 = TMR_W'(FAIL_HI - 1);
  localparam logic [TMR_W-1:0] FL_M1 = TMR_W'(FAIL_LO - 1);
  localparam logic [TMR_W-1:0] GP_M1 = TMR_W'(GAP_LO - 1);

  pg_state_e           st_q, st_d;
  logic [TMR_W-1:0]    tmr_q, tmr_d;
  logic [PCOUNT_W-1:0] left_q, left_d;
  logic                slow_q, slow_d;
  logic                upd_en;
  logic                tmr_zero;

  assign tmr_zero = (tmr_q == '0);
  assign upd_en   = (st_q != PG_IDLE) || go_i;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    left_d = left_q;
    slow_d = slow_q;
    done_o = 1'b0;
    unique case (st_q)
      PG_IDLE: begin
        if (go_i) begin
          st_d   = PG_HIGH;
          slow_d = slow_i;
          left_d = count_i;
          tmr_d  = slow_i ? FH_M1 : PH_M1;
        end
      end
      PG_HIGH: begin
        if (tmr_zero) begin
          st_d  = PG_LOW;
          tmr_d = slow_q ? FL_M1 : PL_M1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      PG_LOW: begin
        if (tmr_zero) begin
          if (left_q == PCOUNT_W'(1)) begin
            st_d  = PG_GAP;
            tmr_d = GP_M1;
          end else begin
            st_d   = PG_HIGH;
            left_d = left_q - 1'b1;
            tmr_d  = slow_q ? FH_M1 : PH_M1;
          end
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      PG_GAP: begin
        if (tmr_zero) begin
          st_d   = PG_IDLE;
          done_o = 1'b1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      default: st_d = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PG_IDLE;
      tmr_q  <= '0;
      left_q <= '0;
      slow_q <= 1'b0;
    end else if (upd_en) begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      left_q <= left_d;
      slow_q <= slow_d;
    end
  end

  assign pulse_o = (st_q == PG_HIGH);
  assign busy_o  = (st_q != PG_IDLE);

  // R3: a burst is never started with zero pulses
  a_r3_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (count_i != '0));
  // R8: busy stays up through the clock after a pulse ends
  a_r8_busy_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> busy_o);
endmodule

// File: rtl/stp_hold_det.sv
module stp_hold_det #(
  parameter int unsigned HOLD_CYCLES = 20459
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic level_i,
  output logic met_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] run_q, run_d;
  logic             met_q, met_d;
  logic             upd_en;

  assign upd_en = en_i && !met_q;

  always_comb begin
    run_d = run_q;
    met_d = met_q;
    if (level_i) begin
      if (run_q == LAST) met_d = 1'b1;
      else               run_d = run_q + 1'b1;
    end else begin
      run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      met_q <= 1'b0;
    end else if (upd_en) begin
      run_q <= run_d;
      met_q <= met_d;
    end
  end

  assign met_o = met_q;

  // R11: once reached, the hold result never drops before reset
  a_r11_met_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    met_q |=> met_q);
  // R10: the result only appears after an enabled high sample
  a_r10_rise_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(met_q) |-> $past(level_i && en_i));
endmodule

// File: rtl/stp_result_latch.sv
module stp_result_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic pass_i,
  output logic pend_o,
  output logic pass_o
);
  logic pend_q, pass_q;
  logic cap_en;

  assign cap_en = strobe_i && !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (cap_en) begin
      pend_q <= 1'b1;
      pass_q <= pass_i;
    end
  end

  assign pend_o = pend_q;
  assign pass_o = pass_q;

  // R9: the first verdict is frozen
  a_r9_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> (pend_q && $stable(pass_q)));
endmodule

// File: rtl/selftest_signaller.sv
module selftest_signaller
  import stp_pkg::*;
#(
  parameter int unsigned PASS_HI     = 4,
  parameter int unsigned PASS_LO     = 4,
  parameter int unsigned FAIL_HI     = 16,
  parameter int unsigned FAIL_LO     = 48,
  parameter int unsigned GAP_LO      = 64,
  parameter int unsigned HOLD_CYCLES = 20459
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sum_strobe_i,
  input  logic sum_pass_i,
  input  logic mem_strobe_i,
  input  logic mem_pass_i,
  input  logic hold_i,
  output logic status_o,
  output logic busy_o
);
  localparam logic [PCOUNT_W-1:0] INTRO_PULSES = PCOUNT_W'(1);
  localparam logic [PCOUNT_W-1:0] SUM_PULSES   = PCOUNT_W'(2);
  localparam logic [PCOUNT_W-1:0] MEM_PULSES   = PCOUNT_W'(3);

  phase_e ph_q, ph_d;

  logic [NUM_CHECKS-1:0] strobe_v, pass_in_v, pend_v, pass_v;
  logic                  go;
  logic [PCOUNT_W-1:0]   go_count;
  logic                  go_slow;
  logic                  pg_pulse, pg_busy, pg_done;
  logic                  hold_en, hold_met;

  assign strobe_v  = {mem_strobe_i, sum_strobe_i};
  assign pass_in_v = {mem_pass_i, sum_pass_i};

  for (genvar i = 0; i < NUM_CHECKS; i++) begin : g_lat
    stp_result_latch u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe_v[i]),
      .pass_i   (pass_in_v[i]),
      .pend_o   (pend_v[i]),
      .pass_o   (pass_v[i])
    );
  end

  always_comb begin
    ph_d     = ph_q;
    go       = 1'b0;
    go_count = '0;
    go_slow  = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        go = 1'b1; go_count = INTRO_PULSES; ph_d = PH_INTRO;
      end
      PH_INTRO:  if (pg_done) ph_d = PH_WAIT_A;
      PH_WAIT_A: if (pend_v[0]) begin
        go = 1'b1; go_count = SUM_PULSES; go_slow = !pass_v[0]; ph_d = PH_SHOW_A;
      end
      PH_SHOW_A: if (pg_done) ph_d = PH_WAIT_B;
      PH_WAIT_B: if (pend_v[1]) begin
        go = 1'b1; go_count = MEM_PULSES; go_slow = !pass_v[1]; ph_d = PH_SHOW_B;
      end
      PH_SHOW_B: if (pg_done) ph_d = PH_HOLD;
      PH_HOLD:   ph_d = PH_HOLD;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  stp_pulse_gen #(
    .PASS_HI (PASS_HI), .PASS_LO (PASS_LO),
    .FAIL_HI (FAIL_HI), .FAIL_LO (FAIL_LO), .GAP_LO (GAP_LO)
  ) u_pg (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (go),
    .count_i (go_count),
    .slow_i  (go_slow),
    .pulse_o (pg_pulse),
    .busy_o  (pg_busy),
    .done_o  (pg_done)
  );

  assign hold_en = (ph_q == PH_HOLD);

  stp_hold_det #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (hold_en),
    .level_i (hold_i),
    .met_o   (hold_met)
  );

  assign status_o = hold_en ? hold_met : pg_pulse;
  assign busy_o   = pg_busy;

  // R7/R8: a new burst is only launched once the previous one is finished
  a_r8_no_go_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !pg_busy);
  // R2: nothing is shown before start
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE) |-> (!status_o && !busy_o));
  // R12: the hold result cannot exist outside the final phase
  a_r12_hold_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_HOLD) |-> !hold_met);
  // R7: the second report only runs after the first verdict was taken
  a_r7_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SHOW_B) |-> pend_v[0]);
endmodule

// File: tb/tb_selftest_signaller.sv
module tb_selftest_signaller;
  localparam int CLK_PERIOD = 10;
  localparam int P_HI = 2, P_LO = 2, F_HI = 4, F_LO = 6, GAP = 8, THRESH = 20;
  localparam int GAP_DET = GAP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, sum_strobe_i = 1'b0, sum_pass_i = 1'b0;
  logic mem_strobe_i = 1'b0, mem_pass_i = 1'b0, hold_i = 1'b0;
  logic status_o, busy_o;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selftest_signaller #(
    .PASS_HI(P_HI), .PASS_LO(P_LO), .FAIL_HI(F_HI), .FAIL_LO(F_LO),
    .GAP_LO(GAP), .HOLD_CYCLES(THRESH)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .sum_strobe_i(sum_strobe_i), .sum_pass_i(sum_pass_i),
    .mem_strobe_i(mem_strobe_i), .mem_pass_i(mem_pass_i),
    .hold_i(hold_i), .status_o(status_o), .busy_o(busy_o)
  );

  // burst monitor on the status pin
  int nb, cur_n, hi_run, lo_run, f_hi, f_lo, f_pre;
  int b_n[8], b_hi[8], b_lo[8], b_pre[8];

  always @(negedge clk) begin
    if (!rst_n) begin
      nb = 0; cur_n = 0; hi_run = 0; lo_run = 0; f_hi = 0; f_lo = 0; f_pre = 0;
    end else if (status_o) begin
      if (hi_run == 0) begin
        if (cur_n == 0) f_pre = lo_run;
        else if (cur_n == 1) f_lo = lo_run;
        cur_n++;
      end
      hi_run++;
      lo_run = 0;
    end else begin
      if (hi_run != 0) begin
        if (cur_n == 1) f_hi = hi_run;
        hi_run = 0;
      end
      lo_run++;
      if (cur_n != 0 && lo_run == GAP_DET && nb < 8) begin
        b_n[nb] = cur_n; b_hi[nb] = f_hi; b_lo[nb] = f_lo; b_pre[nb] = f_pre;
        nb++; cur_n = 0; f_hi = 0; f_lo = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_i = 0; sum_strobe_i = 0; mem_strobe_i = 0;
    sum_pass_i = 0; mem_pass_i = 0; hold_i = 0;
    repeat (3) @(negedge clk);
    check(status_o == 1'b0, "R1 status in reset", int'(status_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobe(input int ch, input bit pass);
    if (ch == 0) begin sum_strobe_i = 1; sum_pass_i = pass; end
    else         begin mem_strobe_i = 1; mem_pass_i = pass; end
    @(negedge clk);
    sum_strobe_i = 0; mem_strobe_i = 0;
  endtask

  task automatic kick();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_bursts(input int want, input string req);
    int k = 0;
    while (nb < want && k < 2000) begin @(negedge clk); k++; end
    check(nb >= want, req, nb, want);
  endtask

  task automatic check_burst(input int i, input int n, input int hi, input int lo, input string req);
    check(b_n[i] == n, {req, " pulse count"}, b_n[i], n);
    check(b_hi[i] == hi, {req, " high length"}, b_hi[i], hi);
    if (n > 1) check(b_lo[i] == lo, {req, " low length"}, b_lo[i], lo);
  endtask

  // R1/R2: quiet before start, early verdicts remembered
  task automatic t_before_start();
    do_reset();
    check(status_o == 1'b0, "R1 status after reset", int'(status_o), 0);
    check(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
    strobe(0, 1'b1);
    strobe(1, 1'b0);
    hold_i = 1'b1;
    repeat (40) @(negedge clk);
    check(status_o == 1'b0, "R2 status before start", int'(status_o), 0);
    check(nb == 0, "R2 no bursts before start", nb, 0);
    check(busy_o == 1'b0, "R2 busy before start", int'(busy_o), 0);
    hold_i = 1'b0;
    kick();
    wait_bursts(3, "R2 remembered verdicts reported");
    check_burst(1, 2, P_HI, P_LO, "R2 early pass of first check");
    check_burst(2, 3, F_HI, F_LO, "R2 early fail of second check");
  endtask

  // R3/R4/R5/R8/R10/R11/R12: full passing run and the hold phase
  task automatic t_all_pass();
    do_reset();
    kick();
    check(status_o == 1'b1, "R3 intro pulse starts", int'(status_o), 1);
    check(busy_o == 1'b1, "R8 busy during burst", int'(busy_o), 1);
    strobe(0, 1'b1);
    wait_bursts(2, "R7 strobe during burst held");
    check_burst(0, 1, P_HI, P_LO, "R3 intro");
    check(b_pre[1] >= GAP + P_LO, "R3 gap before next burst", b_pre[1], GAP + P_LO);
    check_burst(1, 2, P_HI, P_LO, "R4 first check pass");
    repeat (5) @(negedge clk);
    check(busy_o == 1'b0, "R8 busy low while waiting", int'(busy_o), 0);
    hold_i = 1'b1;
    repeat (40) @(negedge clk);
    check(status_o == 1'b0, "R12 hold ignored before final phase", int'(status_o), 0);
    check(nb == 2, "R12 no burst from hold input", nb, 2);
    hold_i = 1'b0;
    strobe(1, 1'b1);
    wait_bursts(3, "R5 second report");
    check_burst(2, 3, P_HI, P_LO, "R5 second check pass");
    repeat (10) @(negedge clk);
    hold_i = 1'b1;
    repeat (10) @(negedge clk);
    hold_i = 1'b0;
    @(negedge clk);
    hold_i = 1'b1;
    repeat (THRESH - 1) @(negedge clk);
    check(status_o == 1'b0, "R10 one clock short of threshold", int'(status_o), 0);
    @(negedge clk);
    check(status_o == 1'b1, "R10 threshold reached", int'(status_o), 1);
    hold_i = 1'b0;
    repeat (10) @(negedge clk);
    check(status_o == 1'b1, "R11 stays high after input drops", int'(status_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(status_o == 1'b0, "R11 cleared by reset", int'(status_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // R6/R7/R9: failures, reversed strobe order, repeated strobe
  task automatic t_fail_order();
    do_reset();
    kick();
    strobe(1, 1'b0);
    strobe(0, 1'b0);
    strobe(0, 1'b1);
    wait_bursts(3, "R7 both reports");
    check_burst(1, 2, F_HI, F_LO, "R6 R7 R9 first check fail shown first");
    check_burst(2, 3, F_HI, F_LO, "R6 R7 second check fail shown second");
  endtask

  initial begin
    t_before_start();
    t_all_pass();
    t_fail_order();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule